// File: doc/BRIEF.md
# Dual Photon Counter for One Readout Pixel

This block holds the digital counting state of a single pixel in a photon-counting detector matrix. Two discriminator hit lines, one for the low threshold and one for the high threshold, drive two counters. Each counter has its own shutter gate. A two-bit depth code sets how wide each counter is: 1, 4 or 12 bits. A fourth code joins both counters into one 24-bit counter. A counter that reaches all ones stops there and keeps that value until it is cleared.

Readout is serial. The active counter bits of every pixel form a shift chain, and each pixel sits between its neighbours in that chain. While the read enable is high, each rising clock edge moves the chain one place. In normal mode both counters stop counting during readout and are read in sequence. In continuous mode only one counter is read and the other keeps counting. A select line chooses which counter plays which role, so the pixel never has to stop acquiring. A fast clear empties both counters in one cycle.

Top module: `pixel_dual_counter`

## Requirements
- R1: While `rst` is high, both counters clear on the next rising edge and `shift_out` reads 0.
- R2: The depth code sets the counter width: 0 gives 1 bit per counter, 1 gives 4 bits, 2 gives 12 bits and 3 joins the counters. In normal mode a readout of 2·width shifts returns counter A first and then counter B, each most significant bit first. In joined mode the readout is 24 shifts.
- R3: In normal mode with `rd_en` high, a bit on `shift_in` enters counter B at bit 0, moves from the top active bit of B into bit 0 of A, and leaves from the top active bit of A on `shift_out`. Bits therefore come out in the order they went in, 2·width shifts later.
- R4: Outside joined mode, a counter that holds all ones in its active bits keeps that value on further hits.
- R5: Depth code 3 in normal mode forms one 24-bit counter with A as the upper half. Hits on `hit_a`, gated by `shut_a`, increment it, and it stops at all ones. `hit_b` and `shut_b` have no effect on it.
- R6: With `crw_en` high, `cnt_sel`=0 selects A for readout and B for counting, and `cnt_sel`=1 selects the reverse. The selected counter alone sits between `shift_in` and `shift_out` and ignores hits. The other counter counts its own hits whether or not `rd_en` is high. Depth code 3 acts as 12 bits in this mode.
- R7: In normal mode, neither counter counts in a cycle where `rd_en` is high.
- R8: `fast_clr` clears both counters on the next edge. It overrides shifting and counting.
- R9: A hit on a counter whose shutter input (`shut_a` or `shut_b`) is low does not change that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and count clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_clr | input | 1 | One-cycle clear of both counters |
| depth_sel | input | 2 | Depth code: 0=1 bit, 1=4 bits, 2=12 bits, 3=joined 24 bits |
| crw_en | input | 1 | Continuous mode: one counter is read while the other counts |
| cnt_sel | input | 1 | In continuous mode, 0 reads A and 1 reads B |
| shut_a | input | 1 | Shutter gate for counter A |
| shut_b | input | 1 | Shutter gate for counter B |
| hit_a | input | 1 | Low-threshold hit; each cycle it is high is one count |
| hit_b | input | 1 | High-threshold hit; each cycle it is high is one count |
| rd_en | input | 1 | Shift the readout chain one place per edge |
| shift_in | input | 1 | Serial data from the previous pixel |
| shift_out | output | 1 | Serial data to the next pixel; the top active bit of the counter being read |

## Verification
The counters can only be seen through the serial chain. A wrong count, a lost carry between the joined halves or a badly placed bit therefore shows up only when that part of the chain reaches `shift_out`. That takes from one shift to 24 shifts after readout starts. The bench follows a model of the chain on every cycle and compares `shift_out` each cycle, so a fault shows up at the first shift that reaches the affected bit. A wrong saturation or a gating fault does not show up in the cycle it happens. It appears in the next readout as a count that is too high or too low. Directed sequences check the 1-, 4-, 12- and 24-bit values against fixed expected words.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic [1:0] {
    DEPTH_1  = 2'd0,
    DEPTH_4  = 2'd1,
    DEPTH_12 = 2'd2,
    DEPTH_24 = 2'd3
  } depth_e;
endpackage

// File: rtl/pxc_lane.sv
module pxc_lane
  import pxc_pkg::*;
#(
  parameter int CW      = 12,
  parameter int SMALL_W = 1,
  parameter int MID_W   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  depth_e        depth,
  input  logic          inc,
  input  logic          wrap_ok,
  input  logic          shift_en,
  input  logic          sin,
  output logic [CW-1:0] val,
  output logic          full,
  output logic          msb
);
  localparam int IW = $clog2(CW);

  logic [CW-1:0] mask;
  logic [CW-1:0] shifted;
  logic [IW-1:0] top_idx;

  always_comb begin
    case (depth)
      DEPTH_1: top_idx = IW'(SMALL_W - 1);
      DEPTH_4: top_idx = IW'(MID_W - 1);
      default: top_idx = IW'(CW - 1);
    endcase
    for (int i = 0; i < CW; i++) begin
      mask[i] = (i <= int'(top_idx));
    end
  end

  assign full    = ((val & mask) == mask);
  assign msb     = val[top_idx];
  assign shifted = ({val[CW-2:0], sin} & mask) | (val & ~mask);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      val <= '0;
    end else if (shift_en) begin
      val <= shifted;
    end else if (inc && (!full || wrap_ok)) begin
      val <= (val + CW'(1)) & mask;
    end
  end
endmodule

// File: rtl/pxc_mode_ctrl.sv
module pxc_mode_ctrl
  import pxc_pkg::*;
(
  input  logic   [1:0] depth_sel,
  input  logic         crw_en,
  input  logic         cnt_sel,
  input  logic         rd_en,
  input  logic         shut_a,
  input  logic         shut_b,
  input  logic         hit_a,
  input  logic         hit_b,
  input  logic         shift_in,
  input  logic         full_a,
  input  logic         full_b,
  input  logic         msb_a,
  input  logic         msb_b,
  output depth_e       lane_depth,
  output logic         inc_a,
  output logic         inc_b,
  output logic         wrap_b,
  output logic         shen_a,
  output logic         shen_b,
  output logic         sin_a,
  output logic         sout
);
  logic joined;
  logic gate_a, gate_b;

  assign joined = !crw_en && (depth_e'(depth_sel) == DEPTH_24);
  assign gate_a = hit_a && shut_a;
  assign gate_b = hit_b && shut_b;

  always_comb begin
    lane_depth = (depth_e'(depth_sel) == DEPTH_24) ? DEPTH_12 : depth_e'(depth_sel);
    wrap_b     = joined;
    if (crw_en) begin
      inc_a  = gate_a && cnt_sel;
      inc_b  = gate_b && !cnt_sel;
      shen_a = rd_en && !cnt_sel;
      shen_b = rd_en && cnt_sel;
      sin_a  = shift_in;
      sout   = cnt_sel ? msb_b : msb_a;
    end else begin
      shen_a = rd_en;
      shen_b = rd_en;
      sin_a  = msb_b;
      sout   = msb_a;
      if (joined) begin
        inc_b = gate_a && !rd_en && !(full_a && full_b);
        inc_a = inc_b && full_b;
      end else begin
        inc_a = gate_a && !rd_en;
        inc_b = gate_b && !rd_en;
      end
    end
  end
endmodule

// File: rtl/pixel_dual_counter.sv
module pixel_dual_counter
  import pxc_pkg::*;
#(
  parameter int CW      = 12,
  parameter int SMALL_W = 1,
  parameter int MID_W   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fast_clr,
  input  logic [1:0] depth_sel,
  input  logic       crw_en,
  input  logic       cnt_sel,
  input  logic       shut_a,
  input  logic       shut_b,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic       rd_en,
  input  logic       shift_in,
  output logic       shift_out
);
  depth_e        lane_depth;
  logic          inc_a, inc_b, wrap_b;
  logic          shen_a, shen_b, sin_a;
  logic          full_a, full_b, msb_a, msb_b;
  logic [CW-1:0] val_a, val_b;

  pxc_mode_ctrl ctrl_i (
    .depth_sel (depth_sel),
    .crw_en    (crw_en),
    .cnt_sel   (cnt_sel),
    .rd_en     (rd_en),
    .shut_a    (shut_a),
    .shut_b    (shut_b),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .shift_in  (shift_in),
    .full_a    (full_a),
    .full_b    (full_b),
    .msb_a     (msb_a),
    .msb_b     (msb_b),
    .lane_depth(lane_depth),
    .inc_a     (inc_a),
    .inc_b     (inc_b),
    .wrap_b    (wrap_b),
    .shen_a    (shen_a),
    .shen_b    (shen_b),
    .sin_a     (sin_a),
    .sout      (shift_out)
  );

  pxc_lane #(.CW(CW), .SMALL_W(SMALL_W), .MID_W(MID_W)) lane_a_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (fast_clr),
    .depth   (lane_depth),
    .inc     (inc_a),
    .wrap_ok (1'b0),
    .shift_en(shen_a),
    .sin     (sin_a),
    .val     (val_a),
    .full    (full_a),
    .msb     (msb_a)
  );

  pxc_lane #(.CW(CW), .SMALL_W(SMALL_W), .MID_W(MID_W)) lane_b_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (fast_clr),
    .depth   (lane_depth),
    .inc     (inc_b),
    .wrap_ok (wrap_b),
    .shift_en(shen_b),
    .sin     (shift_in),
    .val     (val_b),
    .full    (full_b),
    .msb     (msb_b)
  );
endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
  parameter int CW    = 12,
  parameter int MID_W = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          fast_clr,
  input logic [1:0]    depth_sel,
  input logic          crw_en,
  input logic          cnt_sel,
  input logic          shut_a,
  input logic          rd_en,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b
);
  localparam logic [MID_W-1:0] MID_FULL = '1;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cnt_a == '0 && cnt_b == '0)); // R1
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (depth_sel == 2'd1 && !rd_en && !fast_clr && cnt_a[MID_W-1:0] == MID_FULL)
    |=> cnt_a[MID_W-1:0] == MID_FULL); // R4
  AST_JOIN_B_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!crw_en && depth_sel == 2'd3 && !shut_a && !rd_en && !fast_clr) |=> $stable(cnt_b)); // R5
  AST_READ_LANE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (crw_en && !cnt_sel && !rd_en && !fast_clr) |=> $stable(cnt_a)); // R6
  AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    fast_clr |=> (cnt_a == '0 && cnt_b == '0)); // R8
  AST_SHUTTER_GATE: assert property (@(posedge clk) disable iff (rst)
    (!shut_a && !rd_en && !fast_clr) |=> $stable(cnt_a)); // R9
endmodule

bind pixel_dual_counter pxc_checker #(.CW(CW), .MID_W(MID_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .fast_clr (fast_clr),
  .depth_sel(depth_sel),
  .crw_en   (crw_en),
  .cnt_sel  (cnt_sel),
  .shut_a   (shut_a),
  .rd_en    (rd_en),
  .cnt_a    (val_a),
  .cnt_b    (val_b)
);

// File: tb/pixel_dual_counter_tb.sv
module pixel_dual_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, fast_clr = 1'b0, crw_en = 1'b0, cnt_sel = 1'b0;
  logic shut_a = 1'b0, shut_b = 1'b0, hit_a = 1'b0, hit_b = 1'b0;
  logic rd_en = 1'b0, shift_in = 1'b0;
  logic [1:0] depth_sel = 2'd2;
  logic shift_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [11:0] ma = '0, mb = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_dual_counter dut_i (
    .clk(clk), .rst(rst), .fast_clr(fast_clr), .depth_sel(depth_sel),
    .crw_en(crw_en), .cnt_sel(cnt_sel), .shut_a(shut_a), .shut_b(shut_b),
    .hit_a(hit_a), .hit_b(hit_b), .rd_en(rd_en), .shift_in(shift_in),
    .shift_out(shift_out)
  );

  function automatic int width_of(input logic [1:0] d);
    return (d == 2'd0) ? 1 : (d == 2'd1) ? 4 : 12;
  endfunction

  function automatic logic [11:0] mask_of(input int n);
    return (n >= 12) ? 12'hFFF : 12'((1 << n) - 1);
  endfunction

  function automatic logic exp_out();
    int n = width_of(depth_sel);
    return (crw_en && cnt_sel) ? mb[n-1] : ma[n-1];
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    int n = width_of(depth_sel);
    logic [11:0] m = mask_of(n);
    logic fa = ((ma & m) == m);
    logic fb = ((mb & m) == m);
    logic [11:0] na = ma, nb = mb;
    if (rst || fast_clr) begin
      na = '0; nb = '0;
    end else if (crw_en) begin
      if (!cnt_sel) begin
        if (rd_en) na = (({ma[10:0], shift_in}) & m) | (ma & ~m);
        if (hit_b && shut_b && !fb) nb = (mb + 12'd1) & m;
      end else begin
        if (rd_en) nb = (({mb[10:0], shift_in}) & m) | (mb & ~m);
        if (hit_a && shut_a && !fa) na = (ma + 12'd1) & m;
      end
    end else if (rd_en) begin
      na = (({ma[10:0], mb[n-1]}) & m) | (ma & ~m);
      nb = (({mb[10:0], shift_in}) & m) | (mb & ~m);
    end else if (depth_sel == 2'd3) begin
      if (hit_a && shut_a && !(fa && fb)) begin
        nb = (mb + 12'd1) & m;
        if (fb) na = (ma + 12'd1) & m;
      end
    end else begin
      if (hit_a && shut_a && !fa) na = (ma + 12'd1) & m;
      if (hit_b && shut_b && !fb) nb = (mb + 12'd1) & m;
    end
    ma = na; mb = nb;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(tag, {23'd0, shift_out}, {23'd0, exp_out()});
  endtask

  task automatic idle_inputs();
    fast_clr = 0; hit_a = 0; hit_b = 0; rd_en = 0; shift_in = 0;
  endtask

  task automatic do_clear();
    idle_inputs(); fast_clr = 1; step("R8"); fast_clr = 0;
  endtask

  task automatic count(input int na, input int nb, input string tag);
    int mx = (na > nb) ? na : nb;
    for (int i = 0; i < mx; i++) begin
      hit_a = (i < na); hit_b = (i < nb); step(tag);
    end
    hit_a = 0; hit_b = 0;
  endtask

  task automatic readout(input int n, input string tag, output logic [23:0] word);
    word = '0;
    rd_en = 1;
    for (int i = 0; i < n; i++) begin
      word = {word[22:0], shift_out};
      step(tag);
    end
    rd_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    void'($urandom(32'd2718));
    @(negedge clk);
    rst = 1; step("R1"); step("R1");
    rst = 0;
    check("R1 out after reset", {23'd0, shift_out}, 24'd0);
    depth_sel = 2'd2; readout(24, "R1", w);
    check("R1 counters zero", w, 24'd0);

    // R4: 4-bit saturation
    shut_a = 1; shut_b = 1; depth_sel = 2'd1; do_clear();
    count(20, 5, "R4");
    readout(8, "R4", w);
    check("R4 saturate 4-bit", w, 24'h0000F5);

    // R2: 1-bit and 12-bit depths
    do_clear(); depth_sel = 2'd0;
    count(3, 0, "R2");
    readout(2, "R2", w);
    check("R2 1-bit depth", w, 24'h000002);
    do_clear(); depth_sel = 2'd2;
    count(300, 7, "R2");
    hit_a = 1; hit_b = 1;             // R7: hits during readout ignored
    readout(24, "R7", w);
    hit_a = 0; hit_b = 0;
    check("R2 R7 12-bit readout with hits", w, 24'h12C007);

    // R3: chain order, first in first out
    do_clear(); depth_sel = 2'd1; rd_en = 1;
    begin
      logic [7:0] pat = 8'b1011_0010;
      for (int i = 7; i >= 0; i--) begin shift_in = pat[i]; step("R3"); end
      shift_in = 0;
      readout(8, "R3", w);
      check("R3 chain order", w, {16'd0, pat});
    end

    // R5: joined 24-bit with hit_b ignored
    do_clear(); depth_sel = 2'd3; shut_b = 0;
    count(4100, 4100, "R5");
    readout(24, "R5", w);
    check("R5 joined carry", w, 24'h001004);
    shut_b = 1;

    // R6: continuous mode
    do_clear(); depth_sel = 2'd1; crw_en = 1; cnt_sel = 1;
    count(3, 3, "R6");
    cnt_sel = 0; hit_b = 1;
    readout(4, "R6", w);
    hit_b = 0;
    check("R6 read A while B counts", w, 24'h000003);
    cnt_sel = 1;
    readout(4, "R6", w);
    check("R6 read B", w, 24'h000004);
    crw_en = 0; cnt_sel = 0;

    // R8: fast clear wins over shift and count
    do_clear(); depth_sel = 2'd1;
    count(6, 6, "R8");
    fast_clr = 1; rd_en = 1; hit_a = 1; hit_b = 1; shift_in = 1; step("R8");
    idle_inputs();
    readout(8, "R8", w);
    check("R8 cleared", w, 24'd0);

    // R9: closed shutter
    do_clear(); shut_a = 0; shut_b = 1;
    count(10, 10, "R9");
    readout(8, "R9", w);
    check("R9 shutter closed on A", w, 24'h00000A);
    shut_a = 1;

    // Random mix, model compare every cycle
    do_clear();
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 64) == 0) begin
        depth_sel = 2'($urandom); crw_en = 1'($urandom); cnt_sel = 1'($urandom);
      end
      fast_clr = (($urandom % 97) == 0);
      shut_a = (($urandom % 8) != 0); shut_b = (($urandom % 8) != 0);
      hit_a = 1'($urandom); hit_b = 1'($urandom);
      rd_en = (($urandom % 4) == 0); shift_in = 1'($urandom);
      step("R2 random");
    end
    idle_inputs();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule